// File: doc/BRIEF.md
# Transmit Byte-Lane Slave with Wired-OR Output

This block is the slave end of a synchronous, byte-lane transmit bus. Each clock the master presents a valid vector and a payload-request vector, one bit per byte lane. One cycle after a request is sampled, the slave drives bytes onto the lanes the master selected:

- Lanes that are valid and request payload take bytes from an internal payload FIFO, which upstream logic fills one byte at a time.
- Lanes that are valid but do not request payload take bytes from a separate overhead byte source.
- Every other lane is driven to zero. Because of this, several slaves can share one return bus through a bitwise OR.

Requests may arrive on every cycle, which gives full throughput. They may also arrive only on a fraction of cycles, when the clock runs faster than the data rate. When a request has more payload lanes than the FIFO holds bytes, the lanes that cannot be served are driven to zero and a sticky underrun flag is set.

Top module: `tx_lane_slave`

## Requirements
- R1: The request vectors sampled at a rising clock edge determine `tx_data` from just after that edge until the next edge: a fixed latency of one cycle.
- R2: Requests on consecutive cycles are all served, with no idle cycle inserted between them.
- R3: After a cycle in which no valid bit was set, every bit of `tx_data` is zero.
- R4: A lane whose valid bit was clear carries zero in the following cycle, whatever the other lanes carry.
- R5: Lane N occupies `tx_data[8N+7:8N]`. Within one request, payload lanes are filled from the FIFO in descending lane order, so the highest requested lane gets the oldest byte.
- R6: Overhead lanes are filled in descending lane order from `ovh_data`. Byte 0 (`ovh_data[7:0]`) goes to the highest overhead lane, byte 1 to the next one, and so on. `ovh_take` combinationally equals the number of overhead lanes in the present request.
- R7: A byte on `pay_wdata` is stored when `pay_push` is high and `pay_full` is low. `pay_full` is high exactly when the FIFO holds DEPTH bytes. A push while full is dropped.
- R8: If a request has more payload lanes than the FIFO holds bytes, the available bytes go to the highest payload lanes in order and the remaining payload lanes carry zero. `underrun` then rises and stays high until reset.
- R9: While `rst_n` is low, `tx_data` is zero, `underrun` is low and the FIFO is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_val | input | LANES | Per-lane valid request from the master |
| req_pay | input | LANES | Per-lane payload request, meaningful where req_val is set |
| pay_push | input | 1 | Write strobe for the payload FIFO |
| pay_wdata | input | 8 | Payload byte to store |
| pay_full | output | 1 | Payload FIFO holds DEPTH bytes |
| ovh_data | input | 8*LANES | Next LANES overhead bytes, byte 0 first |
| ovh_take | output | $clog2(LANES+1) | Number of overhead bytes consumed this cycle |
| tx_data | output | 8*LANES | Lane data driven toward the wired-OR bus |
| underrun | output | 1 | Sticky payload starvation flag |

## Verification
The hardest situation to reach is partial starvation. It needs a request with more payload lanes than the FIFO holds bytes while the FIFO is not empty, so that some lanes are served and lower ones are zeroed. It also needs a push to land in the same cycle as that pop. To get there, the stimulus fills the FIFO and then stops pushing during dense all-payload requests. The FIFO then drains through counts between one and the lane count, and the behavioural queue model predicts exactly which lanes go empty.

// File: rtl/tx_lane_pkg.sv
package tx_lane_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/lane_rank.sv
// For each lane, counts the selected lanes above it (descending fill order).
module lane_rank #(
  parameter int unsigned LANES = 4,
  localparam int unsigned RW = $clog2(LANES + 1)
) (
  input  logic [LANES-1:0]         mask,
  output logic [LANES-1:0][RW-1:0] rank,
  output logic [RW-1:0]            total
);
  logic [RW-1:0] acc;

  always_comb begin
    acc = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      rank[i] = acc;
      if (mask[i]) acc = acc + RW'(1);
    end
    total = acc;
  end
endmodule

// File: rtl/pay_fifo.sv
// Payload FIFO: one push per cycle, up to LANES pops per cycle with look-ahead.
module pay_fifo
  import tx_lane_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned LANES = 4,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1),
  localparam int unsigned RW = $clog2(LANES + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 push,
  input  byte_t                wdata,
  input  logic [RW-1:0]        pop_cnt,
  output byte_t [LANES-1:0]    peek,
  output logic [CW-1:0]        count
);
  byte_t         mem [DEPTH];
  logic [AW-1:0] rd_ptr, rd_nxt, wr_ptr, wr_nxt;
  logic [CW-1:0] cnt_nxt;
  logic          push_ok;

  assign push_ok = push && (count != CW'(DEPTH));

  always_comb begin
    rd_nxt  = rd_ptr + AW'(pop_cnt);
    wr_nxt  = push_ok ? wr_ptr + AW'(1) : wr_ptr;
    cnt_nxt = count + CW'(push_ok) - CW'(pop_cnt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      rd_ptr <= rd_nxt;
      wr_ptr <= wr_nxt;
      count  <= cnt_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wdata;
  end

  for (genvar i = 0; i < LANES; i++) begin : g_peek
    assign peek[i] = mem[rd_ptr + AW'(i)];
  end

  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    32'(count) <= DEPTH);
  a_r8_pop_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    32'(pop_cnt) <= 32'(count));
endmodule

// File: rtl/tx_lane_slave.sv
module tx_lane_slave
  import tx_lane_pkg::*;
#(
  parameter int unsigned LANES = 4,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned RW = $clog2(LANES + 1),
  localparam int unsigned CW = $clog2(DEPTH + 1),
  localparam int unsigned DW = BYTE_W * LANES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] req_val,
  input  logic [LANES-1:0] req_pay,
  input  logic             pay_push,
  input  logic [7:0]       pay_wdata,
  output logic             pay_full,
  input  logic [DW-1:0]    ovh_data,
  output logic [RW-1:0]    ovh_take,
  output logic [DW-1:0]    tx_data,
  output logic             underrun
);
  logic [1:0]                rst_sync;
  logic                      rst_core_n;
  logic [LANES-1:0]          pay_mask, ovh_mask;
  logic [LANES-1:0][RW-1:0]  pay_rank, ovh_rank;
  logic [RW-1:0]             pay_total, ovh_total, pop_cnt;
  byte_t [LANES-1:0]         peek;
  logic [CW-1:0]             fifo_count;
  logic                      starve;
  logic [DW-1:0]             data_nxt;
  logic                      und_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_core_n = rst_sync[1];

  assign pay_mask = req_val & req_pay;
  assign ovh_mask = req_val & ~req_pay;

  lane_rank #(.LANES(LANES)) u_pay_rank (
    .mask(pay_mask), .rank(pay_rank), .total(pay_total));
  lane_rank #(.LANES(LANES)) u_ovh_rank (
    .mask(ovh_mask), .rank(ovh_rank), .total(ovh_total));

  pay_fifo #(.DEPTH(DEPTH), .LANES(LANES)) u_fifo (
    .clk(clk), .rst_n(rst_core_n), .push(pay_push), .wdata(pay_wdata),
    .pop_cnt(pop_cnt), .peek(peek), .count(fifo_count));

  assign starve   = 32'(pay_total) > 32'(fifo_count);
  assign pop_cnt  = starve ? RW'(fifo_count) : pay_total;
  assign ovh_take = ovh_total;
  assign pay_full = (fifo_count == CW'(DEPTH));

  always_comb begin
    data_nxt = '0;
    for (int i = 0; i < LANES; i++) begin
      if (pay_mask[i] && (pay_rank[i] < pop_cnt))
        data_nxt[8*i +: 8] = peek[int'(pay_rank[i])];
      else if (ovh_mask[i])
        data_nxt[8*i +: 8] = ovh_data[8*int'(ovh_rank[i]) +: 8];
    end
    und_nxt = underrun | starve;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      tx_data  <= '0;
      underrun <= 1'b0;
    end else begin
      tx_data <= data_nxt;
      if (starve) underrun <= und_nxt;
    end
  end

  a_r3_idle_zero: assert property (@(posedge clk) disable iff (!rst_core_n)
    (req_val == '0) |=> (tx_data == '0));
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_core_n)
    underrun |=> underrun);
  a_r6_no_ovh_when_idle: assert property (@(posedge clk) disable iff (!rst_core_n)
    (req_val == '0) |-> (ovh_take == '0));

  for (genvar i = 0; i < LANES; i++) begin : g_lane_chk
    a_r4_lane_zero: assert property (@(posedge clk) disable iff (!rst_core_n)
      !req_val[i] |=> (tx_data[8*i +: 8] == 8'h00));
  end
endmodule

// File: tb/tx_lane_slave_bench.sv
`timescale 1ns/1ps
module tx_lane_slave_bench;
  localparam int L = 4;
  localparam int D = 8;
  localparam int RW = $clog2(L + 1);

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [L-1:0]    req_val = '0, req_pay = '0;
  logic            pay_push = 1'b0;
  logic [7:0]      pay_wdata = '0;
  logic            pay_full;
  logic [8*L-1:0]  ovh_data = '0;
  logic [RW-1:0]   ovh_take;
  logic [8*L-1:0]  tx_data;
  logic            underrun;

  always #2 clk = ~clk;

  tx_lane_slave #(.LANES(L), .DEPTH(D)) u_tx_lane_slave (
    .clk(clk), .rst_n(rst_n), .req_val(req_val), .req_pay(req_pay),
    .pay_push(pay_push), .pay_wdata(pay_wdata), .pay_full(pay_full),
    .ovh_data(ovh_data), .ovh_take(ovh_take), .tx_data(tx_data),
    .underrun(underrun));

  int n_checks = 0, n_fail = 0;
  bit done = 0;
  byte unsigned q[$];
  int ovh_base = 0;
  byte unsigned wr_byte = 8'h10;
  logic [8*L-1:0] exp_data = '0;
  bit exp_und = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic step(input logic [L-1:0] v, input logic [L-1:0] p,
                      input bit push, input string tag);
    int k;
    int pre;
    @(negedge clk);
    check(tx_data == exp_data, tag, tx_data, exp_data);
    check(underrun == exp_und, "R8 underrun", underrun, exp_und);
    check(pay_full == (q.size() == D), "R7 pay_full", pay_full, q.size() == D);
    req_val = v; req_pay = p; pay_push = push; pay_wdata = wr_byte;
    for (int i = 0; i < L; i++) ovh_data[8*i +: 8] = 8'(ovh_base + i);
    #1;
    k = 0;
    for (int i = 0; i < L; i++) if (v[i] && !p[i]) k++;
    check(int'(ovh_take) == k, "R6 ovh_take", ovh_take, k);
    pre = q.size();
    exp_data = '0;
    k = 0;
    for (int i = L - 1; i >= 0; i--) begin
      if (v[i] && p[i]) begin
        if (q.size() > 0) exp_data[8*i +: 8] = q.pop_front();
        else exp_und = 1;
      end else if (v[i]) begin
        exp_data[8*i +: 8] = 8'(ovh_base + k);
        k++;
      end
    end
    ovh_base += k;
    if (push && pre < D) q.push_back(wr_byte);
    if (push) wr_byte = wr_byte + 8'd7;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; req_val = '0; req_pay = '0; pay_push = 0;
    #1;
    check(tx_data == '0, "R9 data", tx_data, 0);
    check(underrun == 1'b0, "R9 underrun", underrun, 0);
    check(pay_full == 1'b0, "R9 full", pay_full, 0);
    q.delete(); exp_data = '0; exp_und = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) step('0, '0, 0, "R9 release");
  endtask

  initial begin
    logic [L-1:0] v, p;
    repeat (3) @(negedge clk);
    check(tx_data == '0 && underrun == 0, "R9 initial", tx_data, 0);
    rst_n = 1'b1;
    repeat (3) step('0, '0, 0, "R9 release");
    // prefill with idle bus
    repeat (D + 2) step('0, '0, 1, "R3 idle zero");
    // payload-only single lanes, descending order
    for (int i = L - 1; i >= 0; i--) step(L'(1) << i, L'(1) << i, 1, "R5 single lane");
    step('1, '1, 1, "R5 all payload");
    // low rate with sparse masks
    for (int c = 0; c < 400; c++) begin
      v = (c % 4 == 0) ? L'($urandom) : '0;
      p = L'($urandom);
      step(v, p & (v & L'(5)), 1, "R1 low rate");
    end
    // overhead-only with unselected lanes
    for (int c = 0; c < 100; c++) step(L'($urandom), '0, 1, "R6 overhead");
    for (int c = 0; c < 100; c++) step(L'($urandom), L'($urandom), 1, "R4 sparse lanes");
    // dense back-to-back, FIFO drains into starvation
    for (int c = 0; c < 200; c++) step('1, L'($urandom) | L'(1), (c % 2) == 0, "R2 back to back");
    for (int c = 0; c < 20; c++) step('1, '1, 0, "R8 starved lanes");
    do_reset();
    repeat (D + 4) step('0, '0, 1, "R7 fill past full");
    for (int c = 0; c < 300; c++) step(L'($urandom), L'($urandom), $urandom % 2, "R5 mixed");
    step('0, '0, 0, "R3 final idle");
    step('0, '0, 0, "R3 final idle");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++;
      $display("FAIL R2 watchdog expired: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule